// File: doc/BRIEF.md
# Phase Lock Status Aggregator

This block turns four independent phase-loss detectors of a digital PLL into one lock status, and derives from that status the loop bandwidth choice and the nearest-edge permit. Each detector can be masked on its own. The fine detector compares the magnitude of a signed phase error against a threshold. The coarse detector compares a whole-cycle slip count against a cycle limit. That limit is decoded from the same 4-bit range code that sets the span of the wide-range phase detector. The frequency-limit detector watches the DCO end-stop flags. The activity detector times the gap between reference edges.

The lock qualifier declares lock only after a programmable number of reference edges have passed with no enabled loss source active. Any enabled loss source removes lock at the next clock edge. While the loop is unlocked it runs at acquisition bandwidth for fast pull-in and nearest-edge detection is withheld. Once it is locked it switches to normal bandwidth and nearest-edge detection is permitted. Producing the phase error, the slip count or the edge pulses is left to neighbouring blocks.

Top module: `phase_lock_agg`

## Requirements
- R1: With `src_en[0]` set, `phase_lost` is 1 after the next clock edge when the absolute value of the two's-complement `fine_err` is strictly greater than `fine_thr`, and 0 when it is equal or smaller (other sources quiet).
- R2: With `src_en[1]` set, loss is flagged after the next edge when `slip_cnt >= N`. N is 2 to the power `range_code` for codes 0 to 12, and N is 8191 for codes 13 to 15.
- R3: With `src_en[2]` set, loss is flagged after the next edge when `dco_at_min` or `dco_at_max` is 1.
- R4: With `src_en[3]` set and `act_timeout` = T, the edge that samples `ref_tick` high restarts an idle count. `phase_lost` then stays 0 through the T-th following edge without a tick and becomes 1 at the (T+1)-th.
- R5: A source whose `src_en` bit is 0 never causes `phase_lost`, whatever its input.
- R6: With no enabled source active, `phase_locked` becomes 1 at the edge that samples the `lock_cycles`-th `ref_tick` pulse since the last loss. Edges without a tick do not advance the count. With `lock_cycles` = 0, lock follows one clean edge.
- R7: Any enabled loss source clears `phase_locked` and restarts the clean-edge count at the next edge.
- R8: `acq_bw` is 1 exactly when `phase_locked` is 0, and `near_edge_ok` equals `phase_locked`.
- R9: During reset, `phase_lost` = 0, `phase_locked` = 0, `acq_bw` = 1 and `near_edge_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference edge |
| fine_err | input | PHASE_W | Signed fine phase error |
| fine_thr | input | PHASE_W | Unsigned fine loss threshold |
| slip_cnt | input | SLIP_W | Whole-cycle slip count |
| range_code | input | 4 | Shared wide-range / coarse cycle code |
| dco_at_min | input | 1 | DCO at its lowest frequency |
| dco_at_max | input | 1 | DCO at its highest frequency |
| src_en | input | 4 | Enables: bit0 fine, bit1 coarse, bit2 limit, bit3 activity |
| lock_cycles | input | CNT_W | Clean reference edges needed for lock |
| act_timeout | input | TO_W | Idle clocks before no-activity loss |
| phase_lost | output | 1 | Registered OR of enabled loss sources |
| phase_locked | output | 1 | Lock status |
| acq_bw | output | 1 | 1 selects acquisition bandwidth |
| near_edge_ok | output | 1 | 1 permits nearest-edge detection |

## Verification
The hardest situation to reach is the exact edge on which lock is declared when reference ticks are sparse. Clock edges without a tick must leave the count alone, and a single stray loss cycle must restart it. The bench first forces loss through a DCO end-stop and then releases it. It feeds ticks on alternate cycles and checks the lock flag one edge before and at the edge of the final tick. It then injects a one-cycle fine error while locked. The activity timeout gets the same edge-exact treatment: one tick followed by a counted run of idle cycles.

// File: rtl/plk_pkg.sv
package plk_pkg;
    localparam int NSRC      = 4;
    localparam int SRC_FINE  = 0;
    localparam int SRC_SLIP  = 1;
    localparam int SRC_LIMIT = 2;
    localparam int SRC_IDLE  = 3;
    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/plk_activity.sv
module plk_activity #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_tick,
    input  logic [TO_W-1:0] act_timeout,
    output logic            no_act
);
    typedef struct packed {
        logic [TO_W-1:0] idle;
    } act_st_t;

    act_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ref_tick) begin
            st_d.idle = '0;
        end else if (st_q.idle != '1) begin
            st_d.idle = st_q.idle + 1'b1;
        end
        no_act = (st_q.idle >= act_timeout);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a reference edge always restarts the idle window
    a_r4_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> (!no_act || act_timeout == '0 || !$stable(act_timeout)));
endmodule

// File: rtl/plk_sources.sv
module plk_sources #(
    parameter int PHASE_W = 12,
    parameter int SLIP_W  = 13
) (
    input  logic signed [PHASE_W-1:0] fine_err,
    input  logic [PHASE_W-1:0]        fine_thr,
    input  logic [SLIP_W-1:0]         slip_cnt,
    input  logic [3:0]                range_code,
    input  logic                      dco_at_min,
    input  logic                      dco_at_max,
    input  logic                      no_act,
    input  plk_pkg::src_vec_t         src_en,
    output plk_pkg::src_vec_t         loss_vec
);
    import plk_pkg::*;

    localparam int MAG_W = PHASE_W + 1;

    logic [MAG_W-1:0]  ext_err;
    logic [MAG_W-1:0]  err_mag;
    logic [SLIP_W-1:0] slip_lim;
    src_vec_t          raw;

    always_comb begin
        ext_err = {fine_err[PHASE_W-1], fine_err};
        err_mag = ext_err[MAG_W-1] ? (~ext_err + 1'b1) : ext_err;
        if (int'(range_code) >= SLIP_W) begin
            slip_lim = '1;
        end else begin
            slip_lim = {{(SLIP_W-1){1'b0}}, 1'b1} << range_code;
        end
        raw            = '0;
        raw[SRC_FINE]  = err_mag > {1'b0, fine_thr};
        raw[SRC_SLIP]  = slip_cnt >= slip_lim;
        raw[SRC_LIMIT] = dco_at_min | dco_at_max;
        raw[SRC_IDLE]  = no_act;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_mask
        assign loss_vec[g] = raw[g] & src_en[g];
    end
endmodule

// File: rtl/plk_lock_qual.sv
module plk_lock_qual #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  plk_pkg::src_vec_t loss_vec,
    input  logic [CNT_W-1:0]  lock_cycles,
    output logic              lost,
    output logic              locked
);
    typedef struct packed {
        logic             lost;
        logic             locked;
        logic [CNT_W-1:0] cnt;
    } lq_st_t;

    lq_st_t st_d, st_q;
    logic   loss_any;

    always_comb begin
        loss_any  = |loss_vec;
        st_d      = st_q;
        st_d.lost = loss_any;
        if (loss_any) begin
            st_d.cnt    = '0;
            st_d.locked = 1'b0;
        end else begin
            if (ref_tick && st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
            st_d.locked = st_q.locked | (st_d.cnt >= lock_cycles);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lost   = st_q.lost;
    assign locked = st_q.locked;

    // R7: loss removes lock at the next edge
    a_r7_loss_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        loss_any |=> (!locked && lost));
    // R6: lock is only gained after a clean cycle
    a_r6_lock_after_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(!loss_any));
endmodule

// File: rtl/phase_lock_agg.sv
module phase_lock_agg #(
    parameter int PHASE_W = 12,
    parameter int SLIP_W  = 13,
    parameter int CNT_W   = 16,
    parameter int TO_W    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ref_tick,
    input  logic signed [PHASE_W-1:0] fine_err,
    input  logic [PHASE_W-1:0]        fine_thr,
    input  logic [SLIP_W-1:0]         slip_cnt,
    input  logic [3:0]                range_code,
    input  logic                      dco_at_min,
    input  logic                      dco_at_max,
    input  logic [3:0]                src_en,
    input  logic [CNT_W-1:0]          lock_cycles,
    input  logic [TO_W-1:0]           act_timeout,
    output logic                      phase_lost,
    output logic                      phase_locked,
    output logic                      acq_bw,
    output logic                      near_edge_ok
);
    import plk_pkg::*;

    logic     no_act;
    src_vec_t loss_vec;

    plk_activity #(.TO_W(TO_W)) i_act (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .act_timeout(act_timeout), .no_act(no_act)
    );

    plk_sources #(.PHASE_W(PHASE_W), .SLIP_W(SLIP_W)) i_src (
        .fine_err(fine_err), .fine_thr(fine_thr), .slip_cnt(slip_cnt),
        .range_code(range_code), .dco_at_min(dco_at_min), .dco_at_max(dco_at_max),
        .no_act(no_act), .src_en(src_en), .loss_vec(loss_vec)
    );

    plk_lock_qual #(.CNT_W(CNT_W)) i_lq (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .loss_vec(loss_vec),
        .lock_cycles(lock_cycles), .lost(phase_lost), .locked(phase_locked)
    );

    assign acq_bw       = ~phase_locked;
    assign near_edge_ok = phase_locked;

    // R5: with every source masked, loss is never reported
    a_r5_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == 4'b0000) |=> !phase_lost);
endmodule

// File: tb/test_phase_lock_agg.sv
module test_phase_lock_agg;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ref_tick = 1'b0;
    logic signed [11:0] fine_err = '0;
    logic [11:0]        fine_thr = 12'd100;
    logic [12:0]        slip_cnt = '0;
    logic [3:0]         range_code = 4'd3;
    logic               dco_at_min = 1'b0;
    logic               dco_at_max = 1'b0;
    logic [3:0]         src_en = 4'b0000;
    logic [15:0]        lock_cycles = 16'd4;
    logic [15:0]        act_timeout = 16'd1000;
    logic               phase_lost, phase_locked, acq_bw, near_edge_ok;
    int                 total = 0;
    int                 bad = 0;

    always #4 clk = ~clk;

    phase_lock_agg i_phase_lock_agg (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fine_err(fine_err),
        .fine_thr(fine_thr), .slip_cnt(slip_cnt), .range_code(range_code),
        .dco_at_min(dco_at_min), .dco_at_max(dco_at_max), .src_en(src_en),
        .lock_cycles(lock_cycles), .act_timeout(act_timeout),
        .phase_lost(phase_lost), .phase_locked(phase_locked),
        .acq_bw(acq_bw), .near_edge_ok(near_edge_ok)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic tick);
        ref_tick = tick;
        @(negedge clk);
    endtask

    task automatic quiet();
        fine_err = '0; slip_cnt = '0; dco_at_min = 0; dco_at_max = 0;
    endtask

    task automatic t_reset();
        chk("R9 lost", phase_lost, 1'b0);
        chk("R9 locked", phase_locked, 1'b0);
        chk("R9 acq", acq_bw, 1'b1);
        chk("R9 near", near_edge_ok, 1'b0);
    endtask

    task automatic t_fine();
        quiet(); src_en = 4'b0001; fine_thr = 12'd100;
        fine_err = 12'sd100;  step(1); chk("R1 equal", phase_lost, 1'b0);
        fine_err = 12'sd101;  step(1); chk("R1 above", phase_lost, 1'b1);
        fine_err = -12'sd100; step(1); chk("R1 neg equal", phase_lost, 1'b0);
        fine_err = -12'sd101; step(1); chk("R1 neg above", phase_lost, 1'b1);
        fine_err = -12'sd2048; step(1); chk("R1 most negative", phase_lost, 1'b1);
        quiet();
    endtask

    task automatic t_coarse();
        quiet(); src_en = 4'b0010;
        range_code = 4'd3;  slip_cnt = 13'd7;    step(1); chk("R2 code3 below", phase_lost, 1'b0);
        slip_cnt = 13'd8;                        step(1); chk("R2 code3 at", phase_lost, 1'b1);
        range_code = 4'd12; slip_cnt = 13'd4095; step(1); chk("R2 code12 below", phase_lost, 1'b0);
        slip_cnt = 13'd4096;                     step(1); chk("R2 code12 at", phase_lost, 1'b1);
        range_code = 4'd15; slip_cnt = 13'd8190; step(1); chk("R2 code15 below", phase_lost, 1'b0);
        slip_cnt = 13'd8191;                     step(1); chk("R2 code15 cap", phase_lost, 1'b1);
        quiet(); range_code = 4'd3;
    endtask

    task automatic t_limit();
        quiet(); src_en = 4'b0100;
        step(1); chk("R3 none", phase_lost, 1'b0);
        dco_at_min = 1; step(1); chk("R3 min", phase_lost, 1'b1);
        dco_at_min = 0; dco_at_max = 1; step(1); chk("R3 max", phase_lost, 1'b1);
        quiet();
    endtask

    task automatic t_activity();
        quiet(); src_en = 4'b1000; act_timeout = 16'd5;
        step(1); step(1);
        for (int k = 1; k <= 5; k++) step(0);
        chk("R4 at timeout", phase_lost, 1'b0);
        step(0); chk("R4 past timeout", phase_lost, 1'b1);
        step(1); step(1); chk("R4 tick clears", phase_lost, 1'b0);
        act_timeout = 16'd1000;
    endtask

    task automatic t_mask();
        src_en = 4'b0000; fine_err = 12'sd900; slip_cnt = 13'd8191;
        dco_at_min = 1; dco_at_max = 1; act_timeout = 16'd2;
        for (int k = 0; k < 4; k++) step(0);
        chk("R5 all masked", phase_lost, 1'b0);
        src_en = 4'b0001; slip_cnt = 13'd8191; fine_err = '0;
        step(0); chk("R5 only fine enabled", phase_lost, 1'b0);
        quiet(); act_timeout = 16'd1000; step(1);
    endtask

    task automatic t_lock();
        src_en = 4'b1111; quiet(); lock_cycles = 16'd4;
        dco_at_max = 1; step(1); dco_at_max = 0;
        chk("R7 loss unlocked", phase_locked, 1'b0);
        for (int k = 0; k < 3; k++) step(1);
        chk("R6 three ticks", phase_locked, 1'b0);
        chk("R8 acq while unlocked", acq_bw, 1'b1);
        step(1);
        chk("R6 fourth tick", phase_locked, 1'b1);
        chk("R8 acq off", acq_bw, 1'b0);
        chk("R8 near edge on", near_edge_ok, 1'b1);
        fine_err = -12'sd150; step(1); fine_err = '0;
        chk("R7 drop", phase_locked, 1'b0);
        chk("R7 lost", phase_lost, 1'b1);
        chk("R8 near edge off", near_edge_ok, 1'b0);
        lock_cycles = 16'd3;
        step(1); step(0); step(1); step(0);
        chk("R6 sparse two ticks", phase_locked, 1'b0);
        step(1);
        chk("R6 sparse third tick", phase_locked, 1'b1);
        dco_at_min = 1; step(0); dco_at_min = 0;
        lock_cycles = 16'd0; step(0);
        chk("R6 zero count", phase_locked, 1'b1);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_fine();
        t_coarse();
        t_limit();
        t_activity();
        t_mask();
        t_lock();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule